// File: doc/BRIEF.md
# Common-Stop Coarse Time-to-Digital Converter

This block measures, for each of sixteen photodetector channels, how long before a trigger that channel's discriminator fired. A free-running counter advances on every cycle of a 320 MHz clock, so one count is about 3.125 ns. Each channel records the count at which its own hit pulse arrives. The trigger acts as one stop for every channel at once. When the stop comes, each channel reports the stop count minus its recorded start count as a 20-bit word, together with a flag that says whether the word holds a real measurement.

Hit pulses come from an analog discriminator that is not locked to the clock. Each hit therefore passes through a two-flop synchronizer. The trigger passes through a matching stage, so the synchronizer delay cancels out of every result. Only hits within 160 counts (500 ns) before the stop are reported. If a channel fired more than once, its most recent hit is used.

When a stop has been taken, all sixteen results are presented together with one done pulse. They stay on the outputs until a clear is given. Stops that arrive in the meantime have no effect.

Top module: `cstop_tdc`

## Requirements
- R1: A channel whose hit is first sampled at clock edge h, with a trigger first sampled at edge s (s > h, s - h <= 160), reports hit flag 1 and time s - h counts. The synchronizer latency does not appear in this value.
- R2: A hit first sampled on the same edge as the trigger reports hit flag 1 and time 0.
- R3: The window is inclusive at 160 counts. A hit exactly 160 counts before the stop is reported as 160 with flag 1. A hit 161 or more counts before the stop reports flag 0 and time 0.
- R4: A channel with no hit in the window reports flag 0 and time 0.
- R5: When a channel is hit several times before the stop, its result is measured from the latest of those hits. Hit inputs are detected on their rising edge.
- R6: doneOut is high for exactly one cycle. It goes high after the second rising edge that follows the edge on which the trigger is first sampled high.
- R7: All channel results change together, on the edge that raises doneOut. They then stay unchanged until a clear.
- R8: A trigger that arrives after a capture and before the next clear produces no done pulse and leaves every output unchanged.
- R9: A one-cycle clearIn after a capture zeroes every time word and hit flag and re-arms the block, so the next trigger is captured normally.
- R10: While rst_n is low and after it is released, doneOut, every hit flag and every time word are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 320 MHz counting clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hitIn | input | 16 | Per-channel discriminator pulses, asynchronous to clk |
| trigIn | input | 1 | Common stop; rising edge taken |
| clearIn | input | 1 | Clears the results and re-arms after a capture |
| timeOut | output | 320 | Channel n time in bits [20n+19:20n], in clock counts |
| hitFlagOut | output | 16 | Bit n is 1 when channel n holds a valid time |
| doneOut | output | 1 | One-cycle pulse when a new set of results appears |

## Verification
The bench places hits at several distances from the stop in one window:

- **Same edge as the stop.** A design that lost a coincident hit would report flag 0 here.
- **Exactly 160 and exactly 161 counts before the stop.** An off-by-one window would flip one of these two flags.
- **Repeated hits on one channel.** A design that kept the first hit would report the larger delay.
- **Channels with no hit at all.** These must read flag 0 and time 0.

The done pulse is checked against the exact edge predicted from the trigger. A synchronizer delay left uncompensated, or a stop path one stage short, would shift every time by a count and move the pulse. A stop sent while results are held must cause neither a pulse nor an output change. Zeroed outputs after a clear, followed by a correct second capture, show that the block re-arms.

// File: rtl/cstop_tdc_pkg.sv
`timescale 1ns/1ps
package cstop_tdc_pkg;

  // Strobes from control to datapath, at most one of them per cycle.
  typedef struct packed {
    logic capture;  // take a snapshot of every channel this edge
    logic clear;    // zero all held results this edge
  } tdcStrobes_t;

  typedef enum logic {
    ST_ARMED = 1'b0,
    ST_HOLD  = 1'b1
  } tdcState_t;

endpackage

// File: rtl/tdc_sync_edge.sv
`timescale 1ns/1ps
// Multi-flop synchronizer followed by a rising-edge detector.
module tdc_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic asyncIn,
  output logic riseOut
);

  logic [STAGES-1:0] syncQ;
  logic              lastQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      syncQ <= '0;
      lastQ <= 1'b0;
    end else begin
      syncQ <= {syncQ[STAGES-2:0], asyncIn};
      lastQ <= syncQ[STAGES-1];
    end
  end

  assign riseOut = syncQ[STAGES-1] & ~lastQ;

endmodule

// File: rtl/tdc_channel.sv
`timescale 1ns/1ps
// One channel: keeps the stamp of its latest hit, ages it out of the
// window, and forms its result when the control asks for a capture.
module tdc_channel #(
  parameter int TIME_W     = 20,
  parameter int RANGE_BINS = 160
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hitRise,
  input  logic [TIME_W-1:0] alignedTime,
  input  logic              captureStb,
  input  logic              clearStb,
  output logic [TIME_W-1:0] timeQ,
  output logic              flagQ
);

  localparam logic [TIME_W-1:0] WindowLimit = TIME_W'(RANGE_BINS);

  logic [TIME_W-1:0] stampQ;
  logic              seenQ;
  logic [TIME_W-1:0] elapsed;
  logic              inWindow;

  // Modular difference. A stamp is dropped well before the counter
  // could wrap back onto it.
  assign elapsed  = alignedTime - stampQ;
  assign inWindow = seenQ && (elapsed <= WindowLimit);

  // Latest hit wins. An old hit is retired once it reaches the limit.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stampQ <= '0;
      seenQ  <= 1'b0;
    end else if (hitRise) begin
      stampQ <= alignedTime;
      seenQ  <= 1'b1;
    end else if (seenQ && (elapsed >= WindowLimit)) begin
      seenQ  <= 1'b0;
    end
  end

  // Result register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      timeQ <= '0;
      flagQ <= 1'b0;
    end else if (captureStb) begin
      if (hitRise) begin
        timeQ <= '0;
        flagQ <= 1'b1;
      end else if (inWindow) begin
        timeQ <= elapsed;
        flagQ <= 1'b1;
      end else begin
        timeQ <= '0;
        flagQ <= 1'b0;
      end
    end else if (clearStb) begin
      timeQ <= '0;
      flagQ <= 1'b0;
    end
  end

endmodule

// File: rtl/tdc_datapath.sv
`timescale 1ns/1ps
// Counter plus the channel array.
module tdc_datapath
  import cstop_tdc_pkg::*;
#(
  parameter int NUM_CH      = 16,
  parameter int TIME_W      = 20,
  parameter int RANGE_BINS  = 160,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_CH-1:0]        hitIn,
  input  tdcStrobes_t              strobes,
  output logic [NUM_CH*TIME_W-1:0] timeOut,
  output logic [NUM_CH-1:0]        hitFlagOut
);

  localparam logic [TIME_W-1:0] SyncLag = TIME_W'(SYNC_STAGES);

  logic [TIME_W-1:0] timeCount;
  logic [TIME_W-1:0] alignedTime;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) timeCount <= '0;
    else        timeCount <= timeCount + 1'b1;
  end

  // Back-date the count by the synchronizer depth. Hits and the stop
  // share this reference, so the lag never reaches a result.
  assign alignedTime = timeCount - SyncLag;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    logic hitRise;

    tdc_sync_edge #(.STAGES(SYNC_STAGES)) sync_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .asyncIn (hitIn[ch]),
      .riseOut (hitRise)
    );

    tdc_channel #(.TIME_W(TIME_W), .RANGE_BINS(RANGE_BINS)) chan_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .hitRise     (hitRise),
      .alignedTime (alignedTime),
      .captureStb  (strobes.capture),
      .clearStb    (strobes.clear),
      .timeQ       (timeOut[ch*TIME_W +: TIME_W]),
      .flagQ       (hitFlagOut[ch])
    );
  end

endmodule

// File: rtl/tdc_ctrl.sv
`timescale 1ns/1ps
// Arm/hold control. The stop passes through the same synchronizer depth
// as the hits.
module tdc_ctrl
  import cstop_tdc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        trigIn,
  input  logic        clearIn,
  output tdcStrobes_t strobes,
  output logic        doneOut
);

  tdcState_t stateQ;
  logic      stopRise;

  tdc_sync_edge #(.STAGES(SYNC_STAGES)) stop_sync_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .asyncIn (trigIn),
    .riseOut (stopRise)
  );

  always_comb begin
    strobes.capture = stopRise && (stateQ == ST_ARMED);
    strobes.clear   = clearIn && !strobes.capture;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stateQ  <= ST_ARMED;
      doneOut <= 1'b0;
    end else begin
      doneOut <= strobes.capture;
      if (strobes.capture)    stateQ <= ST_HOLD;
      else if (strobes.clear) stateQ <= ST_ARMED;
    end
  end

endmodule

// File: rtl/cstop_tdc.sv
`timescale 1ns/1ps
module cstop_tdc
  import cstop_tdc_pkg::*;
#(
  parameter int NUM_CH      = 16,
  parameter int TIME_W      = 20,
  parameter int RANGE_BINS  = 160,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_CH-1:0]        hitIn,
  input  logic                     trigIn,
  input  logic                     clearIn,
  output logic [NUM_CH*TIME_W-1:0] timeOut,
  output logic [NUM_CH-1:0]        hitFlagOut,
  output logic                     doneOut
);

  tdcStrobes_t strobes;

  tdc_ctrl #(.SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .trigIn  (trigIn),
    .clearIn (clearIn),
    .strobes (strobes),
    .doneOut (doneOut)
  );

  tdc_datapath #(
    .NUM_CH      (NUM_CH),
    .TIME_W      (TIME_W),
    .RANGE_BINS  (RANGE_BINS),
    .SYNC_STAGES (SYNC_STAGES)
  ) dp_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .hitIn      (hitIn),
    .strobes    (strobes),
    .timeOut    (timeOut),
    .hitFlagOut (hitFlagOut)
  );

endmodule

// File: rtl/cstop_tdc_chk.sv
`timescale 1ns/1ps
module cstop_tdc_chk #(
  parameter int NUM_CH     = 16,
  parameter int TIME_W     = 20,
  parameter int RANGE_BINS = 160
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     clearIn,
  input logic [NUM_CH*TIME_W-1:0] timeOut,
  input logic [NUM_CH-1:0]        hitFlagOut,
  input logic                     doneOut
);

  logic doneSeenQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       doneSeenQ <= 1'b0;
    else if (clearIn) doneSeenQ <= 1'b0;
    else if (doneOut) doneSeenQ <= 1'b1;
  end

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    doneOut |=> !doneOut);

  // R8
  one_done_per_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    doneOut |-> !doneSeenQ);

  // R7
  results_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!doneOut && !$past(clearIn)) |-> ($stable(timeOut) && $stable(hitFlagOut)));

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_lane
    // R4
    no_hit_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !hitFlagOut[ch] |-> (timeOut[ch*TIME_W +: TIME_W] == '0));

    // R3
    in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hitFlagOut[ch] |-> (timeOut[ch*TIME_W +: TIME_W] <= TIME_W'(RANGE_BINS)));
  end

endmodule

bind cstop_tdc cstop_tdc_chk #(
  .NUM_CH     (NUM_CH),
  .TIME_W     (TIME_W),
  .RANGE_BINS (RANGE_BINS)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .clearIn    (clearIn),
  .timeOut    (timeOut),
  .hitFlagOut (hitFlagOut),
  .doneOut    (doneOut)
);

// File: tb/cstop_tdc_tb_top.sv
`timescale 1ns/1ps
module cstop_tdc_tb_top;

  localparam int      NCH        = 16;
  localparam int      TW         = 20;
  localparam int      WIN        = 160;
  localparam int      SPAN       = 170;
  localparam realtime CLK_PERIOD = 3.125;

  typedef struct packed {
    logic [NCH*TW-1:0] t;
    logic [NCH-1:0]    f;
    logic [31:0]       due;
  } exp_t;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NCH-1:0]    hitIn = '0;
  logic              trigIn = 1'b0;
  logic              clearIn = 1'b0;
  logic [NCH*TW-1:0] timeOut;
  logic [NCH-1:0]    hitFlagOut;
  logic              doneOut;

  cstop_tdc dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .hitIn      (hitIn),
    .trigIn     (trigIn),
    .clearIn    (clearIn),
    .timeOut    (timeOut),
    .hitFlagOut (hitFlagOut),
    .doneOut    (doneOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int edgeCnt = 0;
  always @(posedge clk) edgeCnt <= edgeCnt + 1;

  exp_t  expQ[$];
  int    checks = 0;
  int    fails = 0;
  int    lastHit[NCH];
  bit    hitSeen[NCH];
  bit    benchArmed = 1'b1;
  int    offA[NCH];
  int    offB[NCH];
  string curTag[NCH];
  bit    finished = 1'b0;

  task automatic check(input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  // Monitor: pops one expected set per done pulse
  always @(negedge clk) begin
    if (rst_n && doneOut) begin
      if (expQ.size() == 0) begin
        check("R8", "done pulse with nothing expected", 1, 0);
      end else begin
        exp_t e;
        e = expQ.pop_front();
        check("R6", "done edge", edgeCnt, e.due);
        for (int ch = 0; ch < NCH; ch++) begin
          check(curTag[ch], $sformatf("ch%0d time", ch),
                timeOut[ch*TW +: TW], e.t[ch*TW +: TW]);
          check(curTag[ch], $sformatf("ch%0d flag", ch),
                hitFlagOut[ch], e.f[ch]);
        end
      end
    end
  end

  // Driver: one window of SPAN+1 cycles. offA/offB give how many counts
  // before the stop each hit lands (-1 = none). The trigger comes last.
  task automatic runWindow();
    for (int c = 0; c <= SPAN; c++) begin
      logic [NCH-1:0] mask;
      @(negedge clk);
      mask = '0;
      for (int ch = 0; ch < NCH; ch++) begin
        if (offA[ch] >= 0 && SPAN - offA[ch] == c) mask[ch] = 1'b1;
        if (offB[ch] >= 0 && SPAN - offB[ch] == c) mask[ch] = 1'b1;
      end
      hitIn = mask;
      for (int ch = 0; ch < NCH; ch++)
        if (mask[ch]) begin
          lastHit[ch] = edgeCnt;
          hitSeen[ch] = 1'b1;
        end
      trigIn = (c == SPAN);
      if (c == SPAN && benchArmed) begin
        exp_t e;
        e.t   = '0;
        e.f   = '0;
        e.due = 32'(edgeCnt + 3);
        for (int ch = 0; ch < NCH; ch++) begin
          int d;
          d = edgeCnt - lastHit[ch];
          if (hitSeen[ch] && d <= WIN) begin
            e.f[ch] = 1'b1;
            e.t[ch*TW +: TW] = TW'(d);
          end
          if (!hitSeen[ch] || offA[ch] < 0)    curTag[ch] = "R4";
          else if (d > WIN)                    curTag[ch] = "R3";
          else if (d == 0)                     curTag[ch] = "R2";
          else if (offB[ch] >= 0)              curTag[ch] = "R5";
          else if (d == WIN)                   curTag[ch] = "R3";
          else                                 curTag[ch] = "R1";
        end
        expQ.push_back(e);
        benchArmed = 1'b0;
      end
    end
    @(negedge clk);
    hitIn  = '0;
    trigIn = 1'b0;
  endtask

  task automatic pulseClear();
    @(negedge clk);
    clearIn = 1'b1;
    @(negedge clk);
    clearIn = 1'b0;
    benchArmed = 1'b1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Watchdog
  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finishRun();
  end

  initial begin
    logic [NCH*TW-1:0] snapT;
    logic [NCH-1:0]    snapF;
    for (int ch = 0; ch < NCH; ch++) begin
      lastHit[ch] = 0;
      hitSeen[ch] = 1'b0;
      curTag[ch]  = "R1";
    end

    // R10: state during reset and after release
    idle(3);
    check("R10", "done in reset", doneOut, 0);
    check("R10", "flags in reset", hitFlagOut, 0);
    rst_n = 1'b1;
    idle(3);
    check("R10", "done after reset", doneOut, 0);
    check("R10", "flags after reset", hitFlagOut, 0);
    check("R10", "times after reset", (timeOut == '0), 1);

    // Event 1: R1 spread, R2 coincident, R3 160/161, R4 none, R5 repeats
    for (int ch = 0; ch < NCH; ch++) begin
      offA[ch] = -1;
      offB[ch] = -1;
    end
    offA[0] = 0;   offA[1] = 1;   offA[2] = 5;   offA[3] = 37;
    offA[4] = 100; offA[5] = 159; offA[6] = 160; offA[7] = 161;
    offA[8] = 170; offA[10] = 2;  offA[11] = 80; offA[13] = 3;
    offA[14] = 120; offA[15] = 12;
    offB[10] = 90; offB[11] = 150; offB[15] = 14;
    runWindow();
    idle(4);
    check("R7", "results present after capture", hitFlagOut[0], 1);

    // R8: a stop while results are held
    snapT = timeOut;
    snapF = hitFlagOut;
    @(negedge clk);
    hitIn[9] = 1'b1;
    trigIn = 1'b1;
    @(negedge clk);
    hitIn = '0;
    trigIn = 1'b0;
    idle(6);
    check("R8", "times unchanged by ignored stop", (timeOut == snapT), 1);
    check("R8", "flags unchanged by ignored stop", hitFlagOut, snapF);

    // R9: clear zeroes everything
    pulseClear();
    idle(2);
    check("R9", "flags after clear", hitFlagOut, 0);
    check("R9", "times after clear", (timeOut == '0), 1);
    check("R9", "no done from clear", doneOut, 0);
    idle(SPAN);

    // Event 2: after re-arm, staggered delays and repeats
    for (int ch = 0; ch < NCH; ch++) begin
      offA[ch] = (ch < 15) ? ch * 10 : -1;
      offB[ch] = -1;
    end
    offB[2] = 150; offB[5] = 52; offA[9] = 0;
    runWindow();
    idle(6);
    pulseClear();
    idle(SPAN);

    // Event 3: window edge on every channel
    for (int ch = 0; ch < NCH; ch++) begin
      offA[ch] = (ch % 2 == 0) ? WIN : WIN + 1;
      offB[ch] = -1;
    end
    runWindow();
    idle(6);
    check("R9", "outstanding expectations", expQ.size(), 0);

    finishRun();
  end

endmodule